// File: doc/BRIEF.md
# Dual-Stack Forth Processor Core

A 16-bit processor built around two hardware stacks, meant to run threaded Forth code at one instruction per clock. The working state is a top-of-stack register T, a data stack whose top in memory is N, a return stack whose top is R, a program counter and an interrupt-enable bit. Every instruction is one 16-bit word. It is a literal, a jump, a conditional jump, a call, or an ALU word. An ALU word picks a function for the new T. In the same word it sets four independent move bits and two signed stack-pointer deltas. A stack shuffle, a return and an arithmetic step can therefore all issue in one cycle.

Instructions are read from a fetch port, which is addressed by the registered program counter. One data port serves program RAM and the I/O space above a boundary address. The core drives that port with a write strobe for stores and a read strobe for loads. A hold input freezes the core in place. An interrupt request comes with a small vector number; when interrupts are enabled, the core calls that vector. Program memory, data RAM and peripherals sit outside the core.

Top module: `dual_stack_core`

## Requirements
- R1: Synchronous reset sets the program counter to 0, both stack pointers to 0 and interrupt enable to 0. So depth (code 14), return depth (code 18) and interrupt-state read (code 17) all read 0.
- R2: A word with bit 15 set is a literal. Its bits 14:0 are pushed as T, zero-extended. The old T moves into N and the program counter advances by one.
- R3: Bits 15:13 = 000 jump to bits 12:0. Bits 15:13 = 010 call bits 12:0 and push PC+1 onto the return stack. An ALU word with the return bit set loads the program counter from R.
- R4: Bits 15:13 = 001 is a conditional jump. It pops T, so N becomes T. It branches to bits 12:0 only if the popped T was zero; otherwise it falls through to PC+1.
- R5: Bits 15:13 = 011 is an ALU word, with the function code in bits 12:8. The result replaces T. The codes are: 0 T, 1 N, 2 T+N, 3 T and N, 4 T or N, 5 T xor N, 6 not T, 7 T equals N, 8 N less than T signed, 9 N shifted right logically by T, 10 T minus one, 11 R, 12 the loaded word, 13 N shifted left by T, 14 data depth, 15 N less than T unsigned, 16 copy T bit 0 into interrupt enable (T kept), 17 interrupt enable as 0 or 1, 18 return depth, 19 T equals zero, 20 core identifier. Unused codes keep T.
- R6: Comparison and equality results are 16'hFFFF when true and 16'h0000 when false.
- R7: In an ALU word, bit 7 writes the old T into N, and bit 6 writes T onto the return stack. Bits 3:2 are the signed return-stack delta and bits 1:0 the signed data-stack delta; 01 means +1 and 11 means -1.
- R8: Bit 5 of an ALU word is a store. In that same cycle the core raises the write strobe, with T as write data and N as address. Bit 0 of an address below 16'h4000 is forced to 0; I/O addresses at or above it keep bit 0. Other instructions do not write.
- R9: Outside a store, the data address is T. Code 12 raises the read strobe and takes its word from a synchronous memory, so it returns the word addressed during the previous cycle.
- R10: While hold is high, the program counter, T, both stacks, both pointers and interrupt enable keep their values, and no write strobe is driven.
- R11: With interrupts enabled and a request present, the fetched word is not executed. Instead the core pushes the current PC, jumps to the zero-extended vector and clears interrupt enable. With interrupts disabled, requests are ignored.
- R12: Depth codes report the number of stack entries: data depth counts N entries pushed, return depth counts return entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Freezes all state while high |
| irq_req | input | 1 | Interrupt request |
| irq_vec | input | VEC_W | Interrupt vector (call target) |
| imem_addr | output | PC_W | Instruction fetch address (program counter) |
| imem_data | input | 16 | Fetched instruction word |
| dmem_addr | output | 16 | Data port address |
| dmem_wdata | output | 16 | Data port write data (T) |
| dmem_we | output | 1 | Data write strobe |
| dmem_re | output | 1 | Data read strobe |
| dmem_rdata | input | 16 | Read data from synchronous memory |

## Verification
The properties assume that hold and irq_req are known at every sampled edge. They also assume the instruction word stays steady from just after one edge to the next, because the program-counter checks read the fetched word at the edge. These checks apply only when no request is present. The stimulus changes inputs one time step after each rising edge and raises requests for a single cycle. Its literals fit in 15 bits, and it uses the default stack sizes, whose entry counts are powers of two.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

  typedef enum logic [4:0] {
    OP_T      = 5'd0,
    OP_N      = 5'd1,
    OP_ADD    = 5'd2,
    OP_AND    = 5'd3,
    OP_OR     = 5'd4,
    OP_XOR    = 5'd5,
    OP_INV    = 5'd6,
    OP_EQ     = 5'd7,
    OP_SLT    = 5'd8,
    OP_SHR    = 5'd9,
    OP_DEC    = 5'd10,
    OP_R      = 5'd11,
    OP_LOAD   = 5'd12,
    OP_SHL    = 5'd13,
    OP_DDEPTH = 5'd14,
    OP_ULT    = 5'd15,
    OP_SETIE  = 5'd16,
    OP_GETIE  = 5'd17,
    OP_RDEPTH = 5'd18,
    OP_ZEQ    = 5'd19,
    OP_ID     = 5'd20
  } alu_op_e;

  // Instruction classes on bits 15:13 (bit 15 alone marks a literal)
  localparam logic [2:0] CLS_JMP  = 3'b000;
  localparam logic [2:0] CLS_CJMP = 3'b001;
  localparam logic [2:0] CLS_CALL = 3'b010;
  localparam logic [2:0] CLS_ALU  = 3'b011;

  typedef struct packed {
    logic [2:0] cls;
    logic [4:0] op;
    logic       t2n;
    logic       t2r;
    logic       n2a;
    logic       r2p;
    logic [1:0] rd;
    logic [1:0] dd;
  } instr_t;

endpackage

// File: rtl/dsc_stack.sv
module dsc_stack #(
  parameter int ENTRIES = 64,
  parameter int W       = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       hold,
  input  logic [1:0]                 delta,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  output logic [W-1:0]               top,
  output logic [$clog2(ENTRIES)-1:0] ptr
);
  localparam int PW = $clog2(ENTRIES);

  logic [W-1:0]  mem [ENTRIES];
  logic [PW-1:0] ptr_n;

  assign ptr_n = ptr + {{(PW-2){delta[1]}}, delta};
  assign top   = mem[ptr];

  always_ff @(posedge clk) begin
    if (rst)        ptr <= '0;
    else if (!hold) ptr <= ptr_n;
  end

  always_ff @(posedge clk) begin
    if (!hold && wr_en) mem[ptr_n] <= wr_data;
  end
endmodule

// File: rtl/dsc_alu.sv
module dsc_alu
  import dsc_pkg::*;
#(
  parameter int          W   = 16,
  parameter int          DPW = 6,
  parameter int          RPW = 6,
  parameter logic [15:0] ID  = 16'h00C5
) (
  input  logic [4:0]     op,
  input  logic [W-1:0]   t,
  input  logic [W-1:0]   n,
  input  logic [W-1:0]   r,
  input  logic [W-1:0]   rdata,
  input  logic [DPW-1:0] dsp,
  input  logic [RPW-1:0] rsp,
  input  logic           ie,
  output logic [W-1:0]   res
);
  always_comb begin
    case (alu_op_e'(op))
      OP_T:      res = t;
      OP_N:      res = n;
      OP_ADD:    res = t + n;
      OP_AND:    res = t & n;
      OP_OR:     res = t | n;
      OP_XOR:    res = t ^ n;
      OP_INV:    res = ~t;
      OP_EQ:     res = {W{t == n}};
      OP_SLT:    res = {W{$signed(n) < $signed(t)}};
      OP_SHR:    res = n >> t;
      OP_DEC:    res = t - W'(1);
      OP_R:      res = r;
      OP_LOAD:   res = rdata;
      OP_SHL:    res = n << t;
      OP_DDEPTH: res = W'(dsp);
      OP_ULT:    res = {W{n < t}};
      OP_SETIE:  res = t;
      OP_GETIE:  res = W'(ie);
      OP_RDEPTH: res = W'(rsp);
      OP_ZEQ:    res = {W{t == '0}};
      OP_ID:     res = W'(ID);
      default:   res = t;
    endcase
  end
endmodule

// File: rtl/dual_stack_core.sv
module dual_stack_core
  import dsc_pkg::*;
#(
  parameter int          DS_DEPTH = 65,
  parameter int          RS_DEPTH = 64,
  parameter int          PC_W     = 13,
  parameter int          VEC_W    = 3,
  parameter logic [15:0] IO_BASE  = 16'h4000,
  parameter logic [15:0] CORE_ID  = 16'h00C5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             irq_req,
  input  logic [VEC_W-1:0] irq_vec,
  output logic [PC_W-1:0]  imem_addr,
  input  logic [15:0]      imem_data,
  output logic [15:0]      dmem_addr,
  output logic [15:0]      dmem_wdata,
  output logic             dmem_we,
  output logic             dmem_re,
  input  logic [15:0]      dmem_rdata
);
  localparam int W      = 16;
  localparam int DS_ENT = DS_DEPTH - 1;
  localparam int DPW    = $clog2(DS_ENT);
  localparam int RPW    = $clog2(RS_DEPTH);

  instr_t          ins;
  logic [PC_W-1:0] pc_q, pc_n, pc_inc;
  logic [W-1:0]    t_q, t_n, n_top, r_top, alu_res, addr_raw;
  logic            ie_q, ie_n, take_irq, is_alu;
  logic [1:0]      d_delta, r_delta;
  logic            d_wr, r_wr, st, ld;
  logic [W-1:0]    r_wdata;
  logic [DPW-1:0]  dsp;
  logic [RPW-1:0]  rsp;

  assign ins      = instr_t'(imem_data);
  assign pc_inc   = pc_q + PC_W'(1);
  assign take_irq = irq_req && ie_q;
  assign is_alu   = !take_irq && ins.cls == CLS_ALU;

  dsc_stack #(.ENTRIES(DS_ENT), .W(W)) u_dstack (
    .clk(clk), .rst(rst), .hold(hold), .delta(d_delta), .wr_en(d_wr),
    .wr_data(t_q), .top(n_top), .ptr(dsp));

  dsc_stack #(.ENTRIES(RS_DEPTH), .W(W)) u_rstack (
    .clk(clk), .rst(rst), .hold(hold), .delta(r_delta), .wr_en(r_wr),
    .wr_data(r_wdata), .top(r_top), .ptr(rsp));

  dsc_alu #(.W(W), .DPW(DPW), .RPW(RPW), .ID(CORE_ID)) u_alu (
    .op(ins.op), .t(t_q), .n(n_top), .r(r_top), .rdata(dmem_rdata),
    .dsp(dsp), .rsp(rsp), .ie(ie_q), .res(alu_res));

  // Next-state decode
  always_comb begin
    pc_n    = pc_inc;
    t_n     = t_q;
    ie_n    = ie_q;
    d_delta = 2'b00;
    r_delta = 2'b00;
    d_wr    = 1'b0;
    r_wr    = 1'b0;
    r_wdata = W'(pc_inc);
    st      = 1'b0;
    ld      = 1'b0;
    if (take_irq) begin
      r_delta = 2'b01;
      r_wr    = 1'b1;
      r_wdata = W'(pc_q);
      pc_n    = PC_W'(irq_vec);
      ie_n    = 1'b0;
    end else if (imem_data[15]) begin
      t_n     = {1'b0, imem_data[14:0]};
      d_delta = 2'b01;
      d_wr    = 1'b1;
    end else begin
      case (ins.cls)
        CLS_JMP:  pc_n = imem_data[PC_W-1:0];
        CLS_CJMP: begin
          t_n     = n_top;
          d_delta = 2'b11;
          if (t_q == '0) pc_n = imem_data[PC_W-1:0];
        end
        CLS_CALL: begin
          r_delta = 2'b01;
          r_wr    = 1'b1;
          pc_n    = imem_data[PC_W-1:0];
        end
        default: begin
          t_n     = alu_res;
          d_delta = ins.dd;
          r_delta = ins.rd;
          d_wr    = ins.t2n;
          r_wr    = ins.t2r;
          r_wdata = t_q;
          st      = ins.n2a;
          ld      = ins.op == OP_LOAD;
          if (ins.op == OP_SETIE) ie_n = t_q[0];
          if (ins.r2p) pc_n = r_top[PC_W-1:0];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
      t_q  <= '0;
      ie_q <= 1'b0;
    end else if (!hold) begin
      pc_q <= pc_n;
      t_q  <= t_n;
      ie_q <= ie_n;
    end
  end

  // Data port: program RAM is word addressed, I/O space byte exact
  assign addr_raw   = (is_alu && ins.n2a) ? n_top : t_q;
  assign dmem_addr  = (addr_raw < IO_BASE) ? {addr_raw[W-1:1], 1'b0} : addr_raw;
  assign dmem_wdata = t_q;
  assign dmem_we    = st && !hold;
  assign dmem_re    = ld && !hold;
  assign imem_addr  = pc_q;
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int          PC_W    = 13,
  parameter logic [15:0] IO_BASE = 16'h4000
) (
  input logic            clk,
  input logic            rst,
  input logic            hold,
  input logic            irq_req,
  input logic [PC_W-1:0] imem_addr,
  input logic [15:0]     imem_data,
  input logic [15:0]     dmem_addr,
  input logic            dmem_we
);
  a_r1_pc_zero_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> imem_addr == '0);

  a_r2_literal_advances_pc: assert property (@(posedge clk) disable iff (rst)
    (!hold && !irq_req && imem_data[15]) |=>
      imem_addr == PC_W'($past(imem_addr) + 1'b1));

  a_r3_jump_lands_on_target: assert property (@(posedge clk) disable iff (rst)
    (!hold && !irq_req && imem_data[15:13] == 3'b000) |=>
      imem_addr == $past(imem_data[PC_W-1:0]));

  a_r3_call_lands_on_target: assert property (@(posedge clk) disable iff (rst)
    (!hold && !irq_req && imem_data[15:13] == 3'b010) |=>
      imem_addr == $past(imem_data[PC_W-1:0]));

  a_r8_ram_store_even: assert property (@(posedge clk) disable iff (rst)
    (dmem_we && dmem_addr < IO_BASE) |-> !dmem_addr[0]);

  a_r10_hold_keeps_pc: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(imem_addr));

  a_r10_hold_blocks_write: assert property (@(posedge clk) disable iff (rst)
    hold |-> !dmem_we);
endmodule

bind dual_stack_core dsc_checker #(.PC_W(PC_W), .IO_BASE(IO_BASE)) u_chk (
  .clk(clk), .rst(rst), .hold(hold), .irq_req(irq_req),
  .imem_addr(imem_addr), .imem_data(imem_data),
  .dmem_addr(dmem_addr), .dmem_we(dmem_we));

// File: tb/dual_stack_core_bench.sv
module dual_stack_core_bench;
  localparam int          CLK_PERIOD = 10;
  localparam logic [15:0] ID_VAL     = 16'h1F2A;
  localparam int          NVEC       = 20;

  logic        clk = 0, rst = 1, hold = 0, irq_req = 0;
  logic [2:0]  irq_vec = '0;
  logic [12:0] imem_addr;
  logic [15:0] imem_data = '0, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re;
  logic [15:0] ram [256];
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_stack_core #(.CORE_ID(ID_VAL)) u_dual_stack_core (
    .clk(clk), .rst(rst), .hold(hold), .irq_req(irq_req), .irq_vec(irq_vec),
    .imem_addr(imem_addr), .imem_data(imem_data), .dmem_addr(dmem_addr),
    .dmem_wdata(dmem_wdata), .dmem_we(dmem_we), .dmem_re(dmem_re),
    .dmem_rdata(dmem_rdata));

  // Synchronous data RAM model
  always @(posedge clk) begin
    if (dmem_we && dmem_addr < 16'h4000) ram[dmem_addr[8:1]] <= dmem_wdata;
    dmem_rdata <= ram[dmem_addr[8:1]];
  end

  function automatic logic [15:0] lit(input logic [15:0] v);
    return {1'b1, v[14:0]};
  endfunction
  function automatic logic [15:0] alu(input logic [4:0] op, input logic t2n,
      input logic t2r, input logic n2a, input logic r2p,
      input logic [1:0] rd, input logic [1:0] dd);
    return {3'b011, op, t2n, t2r, n2a, r2p, rd, dd};
  endfunction
  localparam logic [15:0] PEEK = {3'b011, 5'd0, 4'b0010, 4'b0000};
  localparam logic [15:0] NOP  = {3'b011, 13'd0};

  // {op, N, T, expected T}
  localparam logic [52:0] VEC [NVEC] = '{
    {5'd0,  16'h0003, 16'h0007, 16'h0007},
    {5'd1,  16'h0003, 16'h0007, 16'h0003},
    {5'd2,  16'h0003, 16'h0007, 16'h000A},
    {5'd3,  16'h0F0F, 16'h00FF, 16'h000F},
    {5'd4,  16'h0F0F, 16'h00FF, 16'h0FFF},
    {5'd5,  16'h0F0F, 16'h00FF, 16'h0FF0},
    {5'd6,  16'h0000, 16'h0F0F, 16'hF0F0},
    {5'd7,  16'h0005, 16'h0005, 16'hFFFF},
    {5'd7,  16'h0005, 16'h0006, 16'h0000},
    {5'd8,  16'h0002, 16'h0007, 16'hFFFF},
    {5'd8,  16'h0007, 16'h0002, 16'h0000},
    {5'd9,  16'h0F00, 16'h0004, 16'h00F0},
    {5'd10, 16'h0000, 16'h0000, 16'hFFFF},
    {5'd13, 16'h0101, 16'h0004, 16'h1010},
    {5'd15, 16'h0007, 16'h0002, 16'h0000},
    {5'd15, 16'h0002, 16'h0007, 16'hFFFF},
    {5'd19, 16'h0003, 16'h0000, 16'hFFFF},
    {5'd19, 16'h0003, 16'h0004, 16'h0000},
    {5'd20, 16'h0001, 16'h0002, ID_VAL},
    {5'd25, 16'h0001, 16'h0033, 16'h0033}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] w);
    imem_data = w;
    @(posedge clk); #1;
  endtask

  task automatic peek(input string tag, input logic [15:0] exp);
    imem_data = PEEK;
    #1 chk(tag, dmem_wdata, exp);
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst = 1; imem_data = NOP;
    repeat (3) @(posedge clk);
    #1 rst = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 pc", 16'(imem_addr), 16'h0000);
    issue(alu(5'd14, 0, 0, 0, 0, 2'b00, 2'b00)); peek("R1 depth", 16'h0000);
    issue(alu(5'd18, 0, 0, 0, 0, 2'b00, 2'b00)); peek("R1 rdepth", 16'h0000);
    issue(alu(5'd17, 0, 0, 0, 0, 2'b00, 2'b00)); peek("R1 ie", 16'h0000);

    // R5 R6 table of ALU functions
    for (int i = 0; i < NVEC; i++) begin
      issue(lit(VEC[i][47:32]));
      issue(lit(VEC[i][31:16]));
      issue(alu(VEC[i][52:48], 0, 0, 0, 0, 2'b00, 2'b00));
      peek($sformatf("R5/R6 op%0d entry%0d", VEC[i][52:48], i), VEC[i][15:0]);
    end

    // R2 literal
    do_reset();
    issue(lit(16'h7FFF));
    chk("R2 pc", 16'(imem_addr), 16'h0001);
    peek("R2 value", 16'h7FFF);

    // R3 jump, call, return
    do_reset();
    issue({3'b000, 13'h0123}); chk("R3 jump", 16'(imem_addr), 16'h0123);
    issue({3'b010, 13'h0040}); chk("R3 call", 16'(imem_addr), 16'h0040);
    issue(alu(5'd11, 0, 0, 0, 0, 2'b00, 2'b00)); peek("R3 ret addr", 16'h0124);
    issue(alu(5'd0, 0, 0, 0, 1, 2'b11, 2'b00));
    chk("R3 return", 16'(imem_addr), 16'h0124);
    issue(alu(5'd18, 0, 0, 0, 0, 2'b00, 2'b00)); peek("R12 rdepth pop", 16'h0000);

    // R4 conditional jump
    do_reset();
    issue(lit(16'h0007)); issue(lit(16'h0000));
    issue({3'b001, 13'h0055}); chk("R4 taken", 16'(imem_addr), 16'h0055);
    peek("R4 popped", 16'h0007);
    issue(lit(16'h0003));
    issue({3'b001, 13'h00AA}); chk("R4 not taken", 16'(imem_addr), 16'h0058);
    peek("R4 popped2", 16'h0007);
    issue(alu(5'd14, 0, 0, 0, 0, 2'b00, 2'b00)); peek("R12 depth", 16'h0001);

    // R7 move bits and deltas
    do_reset();
    issue(lit(16'h0001)); issue(lit(16'h0002));
    issue(alu(5'd1, 1, 0, 0, 0, 2'b00, 2'b00)); peek("R7 swap T", 16'h0001);
    issue(alu(5'd1, 0, 0, 0, 0, 2'b00, 2'b00)); peek("R7 swap N", 16'h0002);
    issue(lit(16'h0321));
    issue(alu(5'd0, 0, 1, 0, 0, 2'b01, 2'b00));
    issue(alu(5'd11, 0, 0, 0, 0, 2'b00, 2'b00)); peek("R7 to R", 16'h0321);
    issue(alu(5'd18, 0, 0, 0, 0, 2'b00, 2'b00)); peek("R7 rdepth", 16'h0001);
    issue(alu(5'd14, 0, 0, 0, 0, 2'b00, 2'b00)); peek("R7 depth3", 16'h0003);
    issue(alu(5'd0, 0, 0, 0, 0, 2'b00, 2'b11));
    issue(alu(5'd14, 0, 0, 0, 0, 2'b00, 2'b00)); peek("R7 drop", 16'h0002);

    // R8 stores
    do_reset();
    issue(lit(16'h0123));
    imem_data = lit(16'h0ABC);
    #1 chk("R8 no we on lit", 16'(dmem_we), 16'h0000);
    @(posedge clk); #1;
    imem_data = PEEK;
    #1 chk("R8 we", 16'(dmem_we), 16'h0001);
    chk("R8 ram addr", dmem_addr, 16'h0122);
    chk("R8 wdata", dmem_wdata, 16'h0ABC);
    @(posedge clk); #1;
    issue(lit(16'h4001)); issue(lit(16'h0005));
    imem_data = PEEK;
    #1 chk("R8 io addr", dmem_addr, 16'h4001);
    @(posedge clk); #1;

    // R9 load through synchronous memory
    do_reset();
    issue(lit(16'h0020)); issue(lit(16'h1357)); issue(PEEK);
    issue(alu(5'd1, 0, 0, 0, 0, 2'b00, 2'b11));
    imem_data = NOP;
    #1 chk("R9 addr from T", dmem_addr, 16'h0020);
    chk("R9 no re", 16'(dmem_re), 16'h0000);
    @(posedge clk); #1;
    imem_data = alu(5'd12, 0, 0, 0, 0, 2'b00, 2'b00);
    #1 chk("R9 re", 16'(dmem_re), 16'h0001);
    @(posedge clk); #1;
    peek("R9 loaded", 16'h1357);

    // R10 hold
    do_reset();
    issue(lit(16'h0111));
    hold = 1;
    issue(lit(16'h0222));
    chk("R10 pc held", 16'(imem_addr), 16'h0001);
    imem_data = PEEK;
    #1 chk("R10 no write", 16'(dmem_we), 16'h0000);
    @(posedge clk); #1;
    hold = 0;
    peek("R10 T kept", 16'h0111);
    issue(alu(5'd14, 0, 0, 0, 0, 2'b00, 2'b00)); peek("R10 depth kept", 16'h0001);

    // R11 interrupts
    do_reset();
    irq_req = 1; irq_vec = 3'd5;
    issue(lit(16'h0044));
    irq_req = 0;
    chk("R11 ignored when off", 16'(imem_addr), 16'h0001);
    do_reset();
    issue(lit(16'h0001));
    issue(alu(5'd16, 0, 0, 0, 0, 2'b00, 2'b00));
    issue(alu(5'd17, 0, 0, 0, 0, 2'b00, 2'b00));
    peek("R11 ie on", 16'h0001);
    irq_req = 1; irq_vec = 3'd7;
    issue(lit(16'h0055));
    irq_req = 0;
    chk("R11 vector", 16'(imem_addr), 16'h0007);
    peek("R11 word skipped", 16'h0001);
    issue(alu(5'd11, 0, 0, 0, 0, 2'b00, 2'b00)); peek("R11 saved pc", 16'h0004);
    issue(alu(5'd17, 0, 0, 0, 0, 2'b00, 2'b00)); peek("R11 ie cleared", 16'h0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule